// File: doc/BRIEF.md
# TDM Audio Sample Slot Bus

This block sequences a frame-based, time-division multiplexed bus that moves 24-bit audio samples between one router engine and a set of processing engines. A frame strobe arrives once per audio sample period (32, 44.1, 48 or 96 kHz frame rates, for example). Each frame holds 64 slots, and each slot holds 4 bus cycles. Each bus cycle advances on one enable tick. The block keeps the slot and cycle counters. It decodes which party owns the current slot and raises that party's grant. It then captures the owner's sample and valid flag into registered bus outputs, together with the slot and cycle at which the sample was taken.

Ownership is hardwired. Slots 0 to 7 belong to the router engine, so the router supplies up to 32 samples per frame. Slot 8+i belongs to processing engine i, for engines 0 to 55, and each engine supplies up to 4 samples per frame. Any listener may capture any transfer by watching the registered slot and cycle indices next to the data. This is how the engines pass samples to one another at the frame rate.

The sequencer has three states, named here as used in the RTL. SEQ_IDLE is the state after reset, before any frame. SEQ_RUN is the state in which the block is counting through a frame. SEQ_HOLD is the state after the last cycle of slot 63 has been transferred. There are three transitions:

- T_START goes from any state to SEQ_RUN on a frame strobe.
- T_STEP goes from SEQ_RUN back to SEQ_RUN on a tick that is not the last one.
- T_END goes from SEQ_RUN to SEQ_HOLD on the tick at slot 63, cycle 3.

Top module: `tdm_slot_bus`

## Requirements
- R1: After reset the state is SEQ_IDLE, with the following port values. `cur_slot`, `cur_cyc`, `bus_slot`, `bus_cyc` and `bus_data` are all zero. `bus_valid`, `router_grant` and every `eng_grant` bit are low. Ticks in SEQ_IDLE cause no transfer.
- R2: A clock with `frame_start` high sets `cur_slot` to 0 and `cur_cyc` to 0 and enters SEQ_RUN. It does so from any state. A tick in the same clock is ignored, and there is no transfer.
- R3: In SEQ_RUN, each tick (with `frame_start` low) is one transfer and advances the position by one bus cycle. Cycle 3 wraps to cycle 0 of the next slot. Clocks without a tick leave the position unchanged.
- R4: The transfer at slot 63, cycle 3 enters SEQ_HOLD. In SEQ_HOLD the position stays at 63/3, no grant is raised, and ticks cause no transfer until the next `frame_start`.
- R5: `router_grant` is high exactly when the state is SEQ_RUN and `cur_slot` is below 8.
- R6: `eng_grant[i]` is high exactly when the state is SEQ_RUN and `cur_slot` equals 8+i. At most one grant, router or engine, is high at any time.
- R7: A transfer whose owner has its valid flag high produces the following values one clock later. `bus_valid` is 1 and `bus_data` is the owner's sample. Engine i's sample is `eng_data[24*i+23 : 24*i]` and its valid flag is `eng_valid[i]`. `bus_slot` and `bus_cyc` are the position at which the transfer took place. Data and valid flags of non-owners have no effect.
- R8: A transfer whose owner's valid flag is low produces `bus_data` = 0 and `bus_valid` = 0. `bus_slot` and `bus_cyc` are still updated to that position.
- R9: `bus_valid` is high for one clock per valid transfer only. In clocks without a transfer it returns low, and `bus_data`, `bus_slot` and `bus_cyc` hold their last values.
- R10: A `frame_start` in the middle of a frame restarts counting from slot 0, cycle 0, and ownership follows the new position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame strobe, one clock per sample period |
| tick | input | 1 | Bus-cycle enable |
| router_data | input | 24 | Router sample for the current position |
| router_valid | input | 1 | Router sample present |
| eng_data | input | 1344 | Engine samples, 24 bits per engine, engine i at bits 24*i upward |
| eng_valid | input | 56 | Per-engine sample present |
| router_grant | output | 1 | Router owns the current slot |
| eng_grant | output | 56 | Engine i owns the current slot |
| cur_slot | output | 6 | Current slot position |
| cur_cyc | output | 2 | Current bus cycle within the slot |
| bus_slot | output | 6 | Slot of the last transfer |
| bus_cyc | output | 2 | Cycle of the last transfer |
| bus_data | output | 24 | Sample of the last transfer, zero if the owner had none |
| bus_valid | output | 1 | One-clock strobe for a valid transfer |

## Verification
A wrong counter or state shows at the ports within one clock. The grants move to the wrong owner at once, because they are decoded from the position registers. The next transfer then carries the wrong `bus_slot`, `bus_cyc` or sample. A sequencer stuck in SEQ_RUN past the final cycle shows as an extra `bus_valid` strobe on the first tick after slot 63, cycle 3. A sequencer that falls into SEQ_HOLD early shows as missing grants and strobes in the later slots. For these reasons the bench checks the grants before every tick and the bus outputs one clock after every tick, across a full frame. It also checks the idle clocks between ticks.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS    = 64,
    parameter int CYC_PER_SLOT = 4,
    parameter int SLOT_W       = $clog2(NUM_SLOTS),
    parameter int CYC_W        = $clog2(CYC_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic              run_o,
    output logic              xfer_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CYC_W-1:0]  LAST_CYC  = CYC_W'(CYC_PER_SLOT - 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              at_last;
    logic              step;

    assign at_last = (slot_q == LAST_SLOT) && (cyc_q == LAST_CYC);
    assign step    = (state_q == SEQ_RUN) && tick && !frame_start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_START, T_STEP, T_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (frame_start) state_d = SEQ_RUN;
            SEQ_RUN: begin
                if (frame_start)          state_d = SEQ_RUN;
                else if (tick && at_last) state_d = SEQ_HOLD;
            end
            SEQ_HOLD: if (frame_start) state_d = SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            cyc_q  <= '0;
        end else if (frame_start) begin
            slot_q <= '0;
            cyc_q  <= '0;
        end else if (step && !at_last) begin
            if (cyc_q == LAST_CYC) begin
                cyc_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        slot_o = slot_q;
        cyc_o  = cyc_q;
        run_o  = (state_q == SEQ_RUN);
        xfer_o = step;
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_q == '0 && cyc_q == '0 && state_q == SEQ_RUN));

    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && !tick && !frame_start) |=> ($stable(slot_q) && $stable(cyc_q)));

    assert_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && tick && !frame_start && at_last) |=> (state_q == SEQ_HOLD));

endmodule

// File: rtl/tdm_owner_decode.sv
module tdm_owner_decode #(
    parameter int NUM_ENG      = 56,
    parameter int ROUTER_SLOTS = 8,
    parameter int SLOT_W       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic               run_i,
    output logic               router_grant_o,
    output logic [NUM_ENG-1:0] eng_grant_o
);

    localparam logic [SLOT_W-1:0] FIRST_ENG_SLOT = SLOT_W'(ROUTER_SLOTS);

    assign router_grant_o = run_i && (slot_i < FIRST_ENG_SLOT);

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        assign eng_grant_o[g] = run_i && (slot_i == SLOT_W'(ROUTER_SLOTS + g));
    end

    assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_grant_o, router_grant_o}));

endmodule

// File: rtl/tdm_bus_mux.sv
module tdm_bus_mux #(
    parameter int NUM_ENG = 56,
    parameter int DATA_W  = 24,
    parameter int SLOT_W  = 6,
    parameter int CYC_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      xfer_i,
    input  logic [SLOT_W-1:0]         slot_i,
    input  logic [CYC_W-1:0]          cyc_i,
    input  logic                      router_grant_i,
    input  logic [NUM_ENG-1:0]        eng_grant_i,
    input  logic [DATA_W-1:0]         router_data_i,
    input  logic                      router_valid_i,
    input  logic [NUM_ENG*DATA_W-1:0] eng_data_i,
    input  logic [NUM_ENG-1:0]        eng_valid_i,
    output logic [SLOT_W-1:0]         bus_slot_o,
    output logic [CYC_W-1:0]          bus_cyc_o,
    output logic [DATA_W-1:0]         bus_data_o,
    output logic                      bus_valid_o
);

    logic [DATA_W-1:0] sel_data;
    logic              sel_valid;

    always_comb begin
        sel_data  = router_grant_i ? router_data_i : '0;
        sel_valid = router_grant_i && router_valid_i;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (eng_grant_i[i]) begin
                sel_data  = sel_data | eng_data_i[i*DATA_W +: DATA_W];
                sel_valid = sel_valid | eng_valid_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_slot_o  <= '0;
            bus_cyc_o   <= '0;
            bus_data_o  <= '0;
            bus_valid_o <= 1'b0;
        end else if (xfer_i) begin
            bus_slot_o  <= slot_i;
            bus_cyc_o   <= cyc_i;
            bus_data_o  <= sel_valid ? sel_data : '0;
            bus_valid_o <= sel_valid;
        end else begin
            bus_valid_o <= 1'b0;
        end
    end

    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !sel_valid) |=> (bus_data_o == '0 && !bus_valid_o));

    assert_pulse_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> !bus_valid_o);

    assert_hold_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> ($stable(bus_data_o) && $stable(bus_slot_o) && $stable(bus_cyc_o)));

endmodule

// File: rtl/tdm_slot_bus.sv
module tdm_slot_bus #(
    parameter int NUM_SLOTS    = 64,
    parameter int CYC_PER_SLOT = 4,
    parameter int ROUTER_SLOTS = 8,
    parameter int DATA_W       = 24,
    localparam int NUM_ENG     = NUM_SLOTS - ROUTER_SLOTS,
    localparam int SLOT_W      = $clog2(NUM_SLOTS),
    localparam int CYC_W       = $clog2(CYC_PER_SLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      tick,
    input  logic [DATA_W-1:0]         router_data,
    input  logic                      router_valid,
    input  logic [NUM_ENG*DATA_W-1:0] eng_data,
    input  logic [NUM_ENG-1:0]        eng_valid,
    output logic                      router_grant,
    output logic [NUM_ENG-1:0]        eng_grant,
    output logic [SLOT_W-1:0]         cur_slot,
    output logic [CYC_W-1:0]          cur_cyc,
    output logic [SLOT_W-1:0]         bus_slot,
    output logic [CYC_W-1:0]          bus_cyc,
    output logic [DATA_W-1:0]         bus_data,
    output logic                      bus_valid
);

    logic run;
    logic xfer;

    tdm_slot_seq #(
        .NUM_SLOTS   (NUM_SLOTS),
        .CYC_PER_SLOT(CYC_PER_SLOT),
        .SLOT_W      (SLOT_W),
        .CYC_W       (CYC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .tick       (tick),
        .slot_o     (cur_slot),
        .cyc_o      (cur_cyc),
        .run_o      (run),
        .xfer_o     (xfer)
    );

    tdm_owner_decode #(
        .NUM_ENG     (NUM_ENG),
        .ROUTER_SLOTS(ROUTER_SLOTS),
        .SLOT_W      (SLOT_W)
    ) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_i        (cur_slot),
        .run_i         (run),
        .router_grant_o(router_grant),
        .eng_grant_o   (eng_grant)
    );

    tdm_bus_mux #(
        .NUM_ENG(NUM_ENG),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W),
        .CYC_W  (CYC_W)
    ) u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_i        (xfer),
        .slot_i        (cur_slot),
        .cyc_i         (cur_cyc),
        .router_grant_i(router_grant),
        .eng_grant_i   (eng_grant),
        .router_data_i (router_data),
        .router_valid_i(router_valid),
        .eng_data_i    (eng_data),
        .eng_valid_i   (eng_valid),
        .bus_slot_o    (bus_slot),
        .bus_cyc_o     (bus_cyc),
        .bus_data_o    (bus_data),
        .bus_valid_o   (bus_valid)
    );

    assert_grant_on_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        router_grant |-> (cur_slot < SLOT_W'(ROUTER_SLOTS)));

endmodule

// File: tb/tb_tdm_slot_bus.sv
module tb_tdm_slot_bus;

    localparam int NE = 56;
    localparam int DW = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0;
    logic           tick = 1'b0;
    logic [DW-1:0]  router_data = '0;
    logic           router_valid = 1'b1;
    logic [NE*DW-1:0] eng_data;
    logic [NE-1:0]  eng_valid = '1;
    logic           router_grant;
    logic [NE-1:0]  eng_grant;
    logic [5:0]     cur_slot, bus_slot;
    logic [1:0]     cur_cyc, bus_cyc;
    logic [DW-1:0]  bus_data;
    logic           bus_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tdm_slot_bus dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tick(tick),
        .router_data(router_data), .router_valid(router_valid),
        .eng_data(eng_data), .eng_valid(eng_valid),
        .router_grant(router_grant), .eng_grant(eng_grant),
        .cur_slot(cur_slot), .cur_cyc(cur_cyc),
        .bus_slot(bus_slot), .bus_cyc(bus_cyc),
        .bus_data(bus_data), .bus_valid(bus_valid)
    );

    function automatic logic [DW-1:0] edat(int i);
        return 24'h500000 + 24'(i * 291);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fs, input logic tk, input logic [DW-1:0] rd);
        @(negedge clk);
        frame_start = fs;
        tick        = tk;
        router_data = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_grants(input int s, input bit run, input string req);
        logic [NE-1:0] eg;
        logic rg;
        eg = '0;
        if (run && s >= 8) eg[s-8] = 1'b1;
        rg = run && (s < 8);
        chk(router_grant == rg, {req, " R5 router_grant"}, 64'(router_grant), 64'(rg));
        chk(eng_grant == eg, {req, " R6 eng_grant"}, 64'(eng_grant), 64'(eg));
    endtask

    task automatic t_reset();
        chk(cur_slot == 0 && cur_cyc == 0, "R1 position", {cur_slot, cur_cyc}, 0);
        chk(bus_slot == 0 && bus_cyc == 0 && bus_data == 0, "R1 bus fields",
            {bus_slot, bus_cyc, bus_data}, 0);
        chk(bus_valid == 0, "R1 bus_valid", 64'(bus_valid), 0);
        chk_grants(0, 0, "R1");
        drive(0, 1, 24'h123456);
        drive(0, 0, 0);
        chk(bus_valid == 0 && bus_data == 0, "R1 tick in idle", {bus_valid, bus_data}, 0);
        chk(cur_slot == 0 && cur_cyc == 0, "R1 idle no advance", {cur_slot, cur_cyc}, 0);
    endtask

    task automatic t_full_frame();
        logic [DW-1:0] rd, expd, held;
        drive(1, 0, 0);
        chk(cur_slot == 0 && cur_cyc == 0, "R2 start position", {cur_slot, cur_cyc}, 0);
        chk(bus_valid == 0, "R2 no strobe on start", 64'(bus_valid), 0);
        for (int k = 0; k < 256; k++) begin
            int s, c;
            s = k / 4;
            c = k % 4;
            chk(cur_slot == 6'(s) && cur_cyc == 2'(c), "R3 position", {cur_slot, cur_cyc},
                {6'(s), 2'(c)});
            chk_grants(s, 1, "frame");
            rd = 24'hA00000 + 24'(k);
            drive(0, 1, rd);
            expd = (s < 8) ? rd : edat(s - 8);
            chk(bus_valid == 1, "R7 bus_valid", 64'(bus_valid), 1);
            chk(bus_data == expd, "R7 bus_data", 64'(bus_data), 64'(expd));
            chk(bus_slot == 6'(s) && bus_cyc == 2'(c), "R7 bus position", {bus_slot, bus_cyc},
                {6'(s), 2'(c)});
            if (k % 3 == 0) begin
                held = bus_data;
                drive(0, 0, 24'h0F0F0F);
                chk(bus_valid == 0, "R9 strobe drops", 64'(bus_valid), 0);
                chk(bus_data == held && bus_slot == 6'(s) && bus_cyc == 2'(c), "R9 hold",
                    {bus_slot, bus_cyc, bus_data}, {6'(s), 2'(c), held});
            end
        end
        chk(cur_slot == 63 && cur_cyc == 3, "R4 hold position", {cur_slot, cur_cyc}, {6'd63, 2'd3});
        chk_grants(63, 0, "R4 hold");
        for (int j = 0; j < 3; j++) begin
            drive(0, 1, 24'h777777);
            chk(bus_valid == 0, "R4 tick in hold", 64'(bus_valid), 0);
        end
        chk(bus_slot == 63 && bus_cyc == 3, "R4 last transfer kept", {bus_slot, bus_cyc},
            {6'd63, 2'd3});
    endtask

    task automatic t_invalid();
        logic exv;
        logic [DW-1:0] expd;
        router_valid = 1'b0;
        eng_valid[1] = 1'b0;
        drive(1, 0, 0);
        for (int k = 0; k < 44; k++) begin
            int s, c;
            s = k / 4;
            c = k % 4;
            drive(0, 1, 24'hBEEF00 + 24'(k));
            exv  = !(s < 8 || s == 9);
            expd = exv ? edat(s - 8) : '0;
            chk(bus_valid == exv, "R8 bus_valid", 64'(bus_valid), 64'(exv));
            chk(bus_data == expd, "R8/R7 bus_data", 64'(bus_data), 64'(expd));
            chk(bus_slot == 6'(s) && bus_cyc == 2'(c), "R8 position still updated",
                {bus_slot, bus_cyc}, {6'(s), 2'(c)});
        end
        router_valid = 1'b1;
        eng_valid    = '1;
    endtask

    task automatic t_restart();
        drive(1, 0, 0);
        for (int k = 0; k < 37; k++) drive(0, 1, 24'h111111);
        chk(cur_slot == 9 && cur_cyc == 1, "R3 mid position", {cur_slot, cur_cyc}, {6'd9, 2'd1});
        chk_grants(9, 1, "R6 slot 9");
        drive(1, 1, 24'h222222);
        chk(bus_valid == 0, "R2 tick ignored on start", 64'(bus_valid), 0);
        chk(cur_slot == 0 && cur_cyc == 0, "R10 restart position", {cur_slot, cur_cyc}, 0);
        chk_grants(0, 1, "R10 restart");
        drive(0, 1, 24'h333333);
        chk(bus_valid == 1 && bus_data == 24'h333333 && bus_slot == 0 && bus_cyc == 0,
            "R10 first transfer after restart", {bus_valid, bus_slot, bus_cyc, bus_data},
            {1'b1, 6'd0, 2'd0, 24'h333333});
    endtask

    initial begin
        for (int i = 0; i < NE; i++) eng_data[i*DW +: DW] = edat(i);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_full_frame();
        t_invalid();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule